// File: doc/BRIEF.md
# Branch Target and Next-PC Selector

This block decides where instruction flow goes after the current instruction of a 64-bit load/store RISC core. It is purely combinational. Decode gives it the current PC, a 3-bit branch kind, a 4-bit condition code, the raw immediate field of the instruction, the value of the register under test, and a register-held target address. Flag-setting instructions earlier in the program supply the NZVC flags.

It returns the next PC and a taken flag. It also returns a link-register write: an enable plus the return address to be written into register 30. All immediates count instructions, not bytes. The block sign-extends each one from its own width and multiplies it by four before adding it to the PC. Compare-with-zero and flag-conditional branches read a 19-bit offset from the low immediate bits. Direct jumps and calls read the full 26-bit field.

Top module: `bpu_next_pc`

## Requirements
- R1: For kind 0 (sequential) and for the unused kind 7, `next_pc_o` is `pc_i + 4` and `taken_o` is 0.
- R2: For kind 1 (branch if zero), the branch is taken exactly when `test_val_i` is zero. The target is `pc_i + 4*sext(imm_i[18:0])`. Otherwise `next_pc_o` is `pc_i + 4`.
- R3: For kind 2 (branch if non-zero), the branch is taken exactly when `test_val_i` is not zero. The target and the fall-through value are the same as in R2.
- R4: For kind 3 (flag branch), the target is computed as in R2. Flags are packed in `flags_i` as bit 3 N, bit 2 Z, bit 1 C and bit 0 V. Code 0 is taken when Z=1. Code 1 is taken when Z=0. Code 10 is taken when N=V. Code 11 is taken when N≠V.
- R5: The remaining codes of kind 3 work as follows. 2 is taken when C=1 and 3 when C=0. 4 is taken when N=1 and 5 when N=0. 6 is taken when V=1 and 7 when V=0. 8 is taken when C=1 and Z=0, and 9 when that is false. 12 is taken when Z=0 and N=V, and 13 when that is false. 14 and 15 are always taken.
- R6: For kind 4 (jump), `taken_o` is 1 and `next_pc_o` is `pc_i + 4*sext(imm_i[25:0])`.
- R7: For kinds 1, 2 and 3, bits 25 to 19 of `imm_i` have no effect on `next_pc_o` or `taken_o`.
- R8: For kind 5 (jump to register), `taken_o` is 1 and `next_pc_o` equals `reg_tgt_i`.
- R9: For kind 6 (call), `taken_o` is 1, `next_pc_o` is computed as in R6, `link_we_o` is 1 and `link_data_o` is `pc_i + 4`.
- R10: `link_we_o` is 0 for every kind other than 6.
- R11: All PC arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 64 | Byte address of the current instruction |
| kind_i | input | 3 | Branch kind, encoded as listed in the requirements |
| cond_i | input | 4 | Condition code for kind 3 |
| imm_i | input | 26 | Raw instruction offset field, counted in instructions |
| test_val_i | input | 64 | Register value tested by kinds 1 and 2 |
| reg_tgt_i | input | 64 | Register value used as the target by kind 5 |
| flags_i | input | 4 | Flags {N, Z, C, V} |
| next_pc_o | output | 64 | Address of the next instruction |
| taken_o | output | 1 | Flow leaves the sequential path |
| link_we_o | output | 1 | Write enable for register 30 |
| link_data_o | output | 64 | Return address for register 30 |

## Verification
Two situations are hard to reach from the ports. One is a 19-bit offset whose sign bit is set while the upper immediate bits hold garbage. The other is a PC near the top of the address space, where the fall-through and the target wrap. The sweep crosses every kind, every condition code and all 16 flag combinations with three PCs, three immediates and three test values. One immediate has bit 18 and bit 25 set together with unrelated upper bits. One PC is 0xFFFF_FFFF_FFFF_FFFC, so both wrap cases are met for every kind.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic [2:0] {
    BK_SEQ  = 3'd0,
    BK_CBZ  = 3'd1,
    BK_CBNZ = 3'd2,
    BK_COND = 3'd3,
    BK_JMP  = 3'd4,
    BK_JREG = 3'd5,
    BK_CALL = 3'd6,
    BK_RSVD = 3'd7
  } br_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/bpu_cond_eval.sv
module bpu_cond_eval
  import bpu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  nzcv_t      flags_i,
  output logic       hit_o
);
  logic [7:0] base;
  logic       inv;

  // code[3:1] picks a base test, code[0] inverts it except for the always pair
  always_comb begin
    base[0] = flags_i.z;
    base[1] = flags_i.c;
    base[2] = flags_i.n;
    base[3] = flags_i.v;
    base[4] = flags_i.c & ~flags_i.z;
    base[5] = (flags_i.n == flags_i.v);
    base[6] = ~flags_i.z & (flags_i.n == flags_i.v);
    base[7] = 1'b1;
  end

  assign inv   = cond_i[0] & (cond_i[3:1] != 3'b111);
  assign hit_o = base[cond_i[3:1]] ^ inv;
endmodule

// File: rtl/bpu_target_gen.sv
module bpu_target_gen #(
  parameter int XLEN  = 64,
  parameter int OFF_W = 19,
  parameter int SHIFT = 2
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  tgt_o
);
  localparam int EXT_W = XLEN - OFF_W - SHIFT;

  logic [XLEN-1:0] disp;

  assign disp  = {{EXT_W{off_i[OFF_W-1]}}, off_i, {SHIFT{1'b0}}};
  assign tgt_o = pc_i + disp;
endmodule

// File: rtl/bpu_next_pc.sv
module bpu_next_pc
  import bpu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int JMP_W  = 26,
  parameter int CB_W   = 19,
  parameter int INSN_B = 4
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [2:0]       kind_i,
  input  logic [3:0]       cond_i,
  input  logic [JMP_W-1:0] imm_i,
  input  logic [XLEN-1:0]  test_val_i,
  input  logic [XLEN-1:0]  reg_tgt_i,
  input  logic [3:0]       flags_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             taken_o,
  output logic             link_we_o,
  output logic [XLEN-1:0]  link_data_o
);
  localparam int SHIFT = $clog2(INSN_B);

  br_kind_e        kind;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] cb_tgt;
  logic [XLEN-1:0] jmp_tgt;
  logic            cond_hit;
  logic            is_zero;

  assign kind    = br_kind_e'(kind_i);
  assign seq_pc  = pc_i + XLEN'(INSN_B);
  assign is_zero = (test_val_i == '0);

  bpu_target_gen #(.XLEN(XLEN), .OFF_W(CB_W), .SHIFT(SHIFT)) i_cb_tgt (
    .pc_i (pc_i),
    .off_i(imm_i[CB_W-1:0]),
    .tgt_o(cb_tgt)
  );

  bpu_target_gen #(.XLEN(XLEN), .OFF_W(JMP_W), .SHIFT(SHIFT)) i_jmp_tgt (
    .pc_i (pc_i),
    .off_i(imm_i),
    .tgt_o(jmp_tgt)
  );

  bpu_cond_eval i_cond (
    .cond_i (cond_i),
    .flags_i(nzcv_t'(flags_i)),
    .hit_o  (cond_hit)
  );

  always_comb begin
    taken_o   = 1'b0;
    next_pc_o = seq_pc;
    unique case (kind)
      BK_CBZ:  taken_o = is_zero;
      BK_CBNZ: taken_o = ~is_zero;
      BK_COND: taken_o = cond_hit;
      BK_JMP, BK_JREG, BK_CALL: taken_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
    if (taken_o) begin
      unique case (kind)
        BK_JREG:         next_pc_o = reg_tgt_i;
        BK_JMP, BK_CALL: next_pc_o = jmp_tgt;
        default:         next_pc_o = cb_tgt;
      endcase
    end
  end

  assign link_we_o   = (kind == BK_CALL);
  assign link_data_o = seq_pc;
endmodule

// File: rtl/bpu_next_pc_chk.sv
module bpu_next_pc_chk #(
  parameter int XLEN = 64
) (
  input logic [XLEN-1:0] pc_i,
  input logic [2:0]      kind_i,
  input logic [XLEN-1:0] test_val_i,
  input logic [XLEN-1:0] reg_tgt_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_data_o
);
  logic [XLEN-1:0] fall;
  assign fall = pc_i + XLEN'(4);

  always_comb begin
    a_r1_seq_fall: assert (!(kind_i == 3'd0 || kind_i == 3'd7) || (!taken_o && next_pc_o == fall));
    a_r2_cbz_nonzero: assert (!(kind_i == 3'd1 && test_val_i != '0) || !taken_o);
    a_r3_cbnz_zero: assert (!(kind_i == 3'd2 && test_val_i == '0) || !taken_o);
    a_r8_jreg_tgt: assert (kind_i != 3'd5 || (taken_o && next_pc_o == reg_tgt_i));
    a_r9_call_link: assert (kind_i != 3'd6 || (link_we_o && link_data_o == fall && taken_o));
    a_r10_link_only_call: assert (link_we_o == (kind_i == 3'd6));
    a_r11_not_taken_wraps: assert (taken_o || next_pc_o == fall);
  end
endmodule

bind bpu_next_pc bpu_next_pc_chk #(.XLEN(XLEN)) i_chk (
  .pc_i       (pc_i),
  .kind_i     (kind_i),
  .test_val_i (test_val_i),
  .reg_tgt_i  (reg_tgt_i),
  .next_pc_o  (next_pc_o),
  .taken_o    (taken_o),
  .link_we_o  (link_we_o),
  .link_data_o(link_data_o)
);

// File: tb/test_bpu_next_pc.sv
module test_bpu_next_pc;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] pc_i = '0;
  logic [2:0]  kind_i = '0;
  logic [3:0]  cond_i = '0;
  logic [25:0] imm_i = '0;
  logic [63:0] test_val_i = '0;
  logic [63:0] reg_tgt_i = '0;
  logic [3:0]  flags_i = '0;
  logic [63:0] next_pc_o, link_data_o;
  logic        taken_o, link_we_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bpu_next_pc i_bpu_next_pc (
    .pc_i(pc_i), .kind_i(kind_i), .cond_i(cond_i), .imm_i(imm_i),
    .test_val_i(test_val_i), .reg_tgt_i(reg_tgt_i), .flags_i(flags_i),
    .next_pc_o(next_pc_o), .taken_o(taken_o),
    .link_we_o(link_we_o), .link_data_o(link_data_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s kind=%0d cond=%0d flags=%h pc=%h imm=%h: act=%h exp=%h",
               req, kind_i, cond_i, flags_i, pc_i, imm_i, act, exp);
    end
  endtask

  function automatic bit cond_ref(logic [3:0] c, logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !(cy && !z);
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return !(!z && (n == v));
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    logic [63:0] pcs [3];
    logic [25:0] imms [3];
    logic [63:0] tvs [3];
    pcs[0] = 64'h0000_0000_0000_1000;
    pcs[1] = 64'hFFFF_FFFF_FFFF_FFFC;
    pcs[2] = 64'h0000_0000_0040_0000;
    imms[0] = 26'h000_0019;
    imms[1] = 26'h3FF_FFFF;
    imms[2] = 26'h2A4_0001;
    tvs[0] = 64'h0;
    tvs[1] = 64'h1;
    tvs[2] = 64'h8000_0000_0000_0000;

    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R1 idle state with all inputs at zero
    @(negedge clk);
    vectors++;
    chk("R1", next_pc_o, 64'h4);
    chk("R1", {63'b0, taken_o}, 64'h0);
    chk("R10", {63'b0, link_we_o}, 64'h0);

    for (int k = 0; k < 8; k++)
      for (int c = 0; c < 16; c++)
        for (int f = 0; f < 16; f++)
          for (int p = 0; p < 3; p++)
            for (int m = 0; m < 3; m++)
              for (int t = 0; t < 3; t++) begin
                logic [63:0] seq, cbt, jt, exp_pc;
                bit tk;
                string req;
                @(posedge clk);
                kind_i = 3'(k); cond_i = 4'(c); flags_i = 4'(f);
                pc_i = pcs[p]; imm_i = imms[m]; test_val_i = tvs[t];
                reg_tgt_i = pcs[p] ^ 64'hA5A5_5A5A_0F0F_F0F0;
                seq = pc_i + 64'd4;
                cbt = pc_i + {{43{imm_i[18]}}, imm_i[18:0], 2'b00};
                jt  = pc_i + {{36{imm_i[25]}}, imm_i, 2'b00};
                case (k)
                  1: begin tk = (test_val_i == 0); req = "R2"; end
                  2: begin tk = (test_val_i != 0); req = "R3"; end
                  3: begin
                    tk = cond_ref(cond_i, flags_i);
                    req = (c == 0 || c == 1 || c == 10 || c == 11) ? "R4" : "R5";
                  end
                  4: begin tk = 1; req = "R6"; end
                  5: begin tk = 1; req = "R8"; end
                  6: begin tk = 1; req = "R9"; end
                  default: begin tk = 0; req = "R1"; end
                endcase
                if (!tk) exp_pc = seq;
                else if (k == 5) exp_pc = reg_tgt_i;
                else if (k == 4 || k == 6) exp_pc = jt;
                else exp_pc = cbt;
                if (k >= 1 && k <= 3 && imm_i[25:19] != 0) req = {req, "/R7"};
                if (p == 1) req = {req, "/R11"};
                @(negedge clk);
                vectors++;
                chk(req, next_pc_o, exp_pc);
                chk(req, {63'b0, taken_o}, {63'b0, tk});
                chk((k == 6) ? "R9" : "R10", {63'b0, link_we_o}, {63'b0, (k == 6)});
                if (k == 6) chk("R9", link_data_o, seq);
              end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule